// File: doc/BRIEF.md
# DMA Channel Arming and Request Qualification

This block sits in front of a simple transfer sequencer and decides, cycle by cycle, which of the DMA channels asks for a transfer. Each channel holds a control word with an arm flag, a synchronization mode, a stop-at-zero flag and an internal-source flag, plus a transfer counter. The arm flag can only be changed by a write that also carries a change-enable bit, so software can rewrite the mode fields of a live channel without arming or disarming it by accident. A single module-wide select bit decides whether every channel that uses internal requests listens to the timer or to the serial port.

Each channel runs a three-state machine. OFF means disarmed. WAIT means armed and waiting for a qualified request. XFER means granted and holding its request until the sequencer strobes done. Transitions: OFF→WAIT on an arming write. WAIT→XFER when the arbiter grants it. XFER→WAIT on done. XFER→OFF on done at terminal count with stop-at-zero set. WAIT/XFER→OFF on a disarming write. A fixed-priority arbiter gives the lowest-numbered channel the request output and never lets a second channel in while one is in XFER.

Top module: `dma_arm_ctrl`

## Requirements
- R1: After reset every channel is OFF, every register reads zero and no request output is high.
- R2: A control write (channel i at address 2i) changes the arm flag (bit 0) only when the change-enable bit (bit 1) is also 1 in that write. Without it, the arm flag keeps its value while sync (bits 3:2), stop-at-zero (bit 4) and internal-source (bit 5) still update.
- R3: A disarmed channel raises no request, whatever its request inputs do.
- R4: With sync 00 (free-running), an armed channel in WAIT requests in every cycle, starting with the first cycle after the arming write.
- R5: With sync 01 (source-paced), a WAIT channel requests in the same cycle in which its selected request input is high.
- R6: With sync 10 (destination-paced), the request input is registered only while the channel is in WAIT. The request appears one cycle after the input rises, and one full WAIT cycle must pass after each transfer before the next request.
- R7: With sync 11 (reserved), the channel stays armed but never requests.
- R8: A control write with internal-source set stores sync 01 whatever the written sync field. The select register (address 2·NUM_CH, bit 0) makes internal-source channels follow the timer request when 0 and the serial-port request when 1.
- R9: The transfer counter (address 2i+1) is loaded by a write and decrements once per done strobe while its channel is in XFER. A write in the same cycle wins.
- R10: A done strobe that takes the counter from 1 to 0 disarms the channel when stop-at-zero is set, and the arm flag then reads 0. Otherwise the channel returns to WAIT, and a done at count 0 wraps the counter.
- R11: At most one request output is high per cycle. Among WAIT channels the lowest index wins. A channel in XFER keeps its output high until done and blocks all others.
- R12: Control reads return the arm flag in bit 0, bit 1 as zero, and the stored fields in their bit positions. Unused addresses read zero.
- R13: A disarming write (change-enable with arm 0) moves a channel to OFF from WAIT or XFER, even when done is strobed in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Combinational read data |
| ext_drq | input | NUM_CH | External request input per channel |
| timer_drq | input | 1 | Timer request for internal-source channels |
| serial_drq | input | 1 | Serial-port request for internal-source channels |
| xfer_done | input | 1 | Sequencer transfer-complete strobe for the granted channel |
| xfer_req | output | NUM_CH | Per-channel transfer request, one-hot or zero |

## Verification
Request outputs are combinational from the channel state and the request inputs, so a source-paced request is due in the cycle its input rises, while a destination-paced request is due one rising edge later. Register writes, counter decrements, disarms and state moves take effect at the next rising edge and show on `rd_data` and `xfer_req` in the following cycle. The bench drives every input just after a falling edge and compares both outputs 1 ns later, well before the next rising edge. After each comparison its model advances by one edge, so every expected value already accounts for each register on the path. Directed sequences pin the literal values at each of these latencies, and a seeded random phase compares the outputs against the model on every cycle.

// File: rtl/dma_arm_pkg.sv
package dma_arm_pkg;

    typedef enum logic [1:0] {
        CH_OFF  = 2'd0,
        CH_WAIT = 2'd1,
        CH_XFER = 2'd2
    } ch_state_e;

    typedef enum logic [1:0] {
        SYN_FREE = 2'd0,
        SYN_SRC  = 2'd1,
        SYN_DST  = 2'd2,
        SYN_RSV  = 2'd3
    } sync_e;

    // control word bit positions (software-visible, decoded by the channel)
    localparam int B_ARM     = 0;
    localparam int B_CHG     = 1;
    localparam int B_SYNC_LO = 2;
    localparam int B_STOP    = 4;
    localparam int B_INT     = 5;
    localparam int CTL_BITS  = 6;

    typedef struct packed {
        logic  use_int;
        logic  stop_tc;
        sync_e sync;
    } ch_cfg_t;

endpackage

// File: rtl/dma_int_src.sv
module dma_int_src (
    input  logic sel_serial,
    input  logic timer_drq,
    input  logic serial_drq,
    output logic int_drq
);
    always_comb begin
        int_drq = sel_serial ? serial_drq : timer_drq;
    end
endmodule

// File: rtl/dma_req_arb.sv
module dma_req_arb #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] cand_i,
    input  logic [NUM_CH-1:0] busy_i,
    output logic [NUM_CH-1:0] grant_o
);
    logic taken;

    always_comb begin
        grant_o = '0;
        taken   = |busy_i;
        if (taken) begin
            grant_o = busy_i;
        end else begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (cand_i[i] && !taken) begin
                    grant_o[i] = 1'b1;
                    taken      = 1'b1;
                end
            end
        end
    end

    // R11: never more than one request out
    p_onehot_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    // R11: only one channel may be mid-transfer
    p_single_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(busy_i));

    // R11: lowest index wins when nobody holds the bus
    p_low_first_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_i == '0) && cand_i[0] |-> grant_o[0]);
endmodule

// File: rtl/dma_chan_ctl.sv
module dma_chan_ctl
    import dma_arm_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic              cnt_we,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ext_drq,
    input  logic              int_drq,
    input  logic              done_i,
    input  logic              grant_i,
    output logic              cand_o,
    output logic              busy_o,
    output logic [DATA_W-1:0] ctl_rd,
    output logic [CNT_W-1:0]  cnt_rd
);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    ch_state_e          st_q, st_d;
    ch_cfg_t            cfg_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               samp_q;
    logic               wr_chg, arm_set, arm_clr, drq, tc_hit;
    sync_e              sync_w;

    always_comb begin
        wr_chg  = ctl_we && wr_data[B_CHG];
        arm_set = wr_chg && wr_data[B_ARM];
        arm_clr = wr_chg && !wr_data[B_ARM];
        drq     = cfg_q.use_int ? int_drq : ext_drq;
        tc_hit  = (cnt_q == CNT_ONE);
        sync_w  = wr_data[B_INT] ? SYN_SRC : sync_e'(wr_data[B_SYNC_LO+1:B_SYNC_LO]);
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_OFF: begin
                if (arm_set) st_d = CH_WAIT;
            end
            CH_WAIT: begin
                if (arm_clr)      st_d = CH_OFF;
                else if (grant_i) st_d = CH_XFER;
            end
            CH_XFER: begin
                if (arm_clr)     st_d = CH_OFF;
                else if (done_i) st_d = (tc_hit && cfg_q.stop_tc) ? CH_OFF : CH_WAIT;
            end
            default: st_d = CH_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CH_OFF;
        else        st_q <= st_d;
    end

    // outputs
    always_comb begin
        busy_o = (st_q == CH_XFER);
        cand_o = 1'b0;
        if (st_q == CH_WAIT) begin
            unique case (cfg_q.sync)
                SYN_FREE: cand_o = 1'b1;
                SYN_SRC:  cand_o = drq;
                SYN_DST:  cand_o = samp_q;
                SYN_RSV:  cand_o = 1'b0;
                default:  cand_o = 1'b0;
            endcase
        end
    end

    always_comb begin
        ctl_rd                       = '0;
        ctl_rd[B_ARM]                = (st_q != CH_OFF);
        ctl_rd[B_SYNC_LO+1:B_SYNC_LO] = cfg_q.sync;
        ctl_rd[B_STOP]               = cfg_q.stop_tc;
        ctl_rd[B_INT]                = cfg_q.use_int;
        cnt_rd                       = cnt_q;
    end

    // configuration fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{use_int: 1'b0, stop_tc: 1'b0, sync: SYN_FREE};
        end else if (ctl_we) begin
            cfg_q <= '{use_int: wr_data[B_INT], stop_tc: wr_data[B_STOP], sync: sync_w};
        end
    end

    // transfer counter
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (cnt_we)           cnt_q <= wr_data[CNT_W-1:0];
        else if (busy_o && done_i) cnt_q <= cnt_q - CNT_ONE;
    end

    // destination-paced sample, taken only between transfers
    always_ff @(posedge clk) begin
        if (!rst_n) samp_q <= 1'b0;
        else        samp_q <= (st_q == CH_WAIT) ? drq : 1'b0;
    end

    // R2: arm flag holds without change-enable (unless terminal count fires)
    p_arm_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_we && wr_data[B_CHG]) && !(busy_o && done_i)
        |=> (st_q == CH_OFF) == $past(st_q == CH_OFF));

    // R3: disarmed channel is silent
    p_off_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == CH_OFF) |-> !cand_o && !busy_o);

    // R7: reserved sync never requests
    p_rsv_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.sync == SYN_RSV) |-> !cand_o);

    // R8: internal source always paired with source pacing
    p_int_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q.use_int |-> (cfg_q.sync == SYN_SRC));

    // R9: one decrement per done while transferring
    p_cnt_dec_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && done_i && !cnt_we |=> cnt_q == $past(cnt_q) - CNT_ONE);

    // R10: terminal count with stop-at-zero disarms
    p_tc_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o && done_i && cfg_q.stop_tc && tc_hit |=> (st_q == CH_OFF));

    // R13: disarming write always lands in OFF
    p_disarm_r13: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we && wr_data[B_CHG] && !wr_data[B_ARM] |=> (st_q == CH_OFF));
endmodule

// File: rtl/dma_arm_ctrl.sv
module dma_arm_ctrl
    import dma_arm_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [NUM_CH-1:0] ext_drq,
    input  logic              timer_drq,
    input  logic              serial_drq,
    input  logic              xfer_done,
    output logic [NUM_CH-1:0] xfer_req
);
    localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(2 * NUM_CH);

    logic              sel_serial_q;
    logic              int_drq;
    logic [NUM_CH-1:0] cand, busy, grant;
    logic [DATA_W-1:0] ctl_rd_a [NUM_CH];
    logic [CNT_W-1:0]  cnt_rd_a [NUM_CH];

    always_ff @(posedge clk) begin
        if (!rst_n)                             sel_serial_q <= 1'b0;
        else if (wr_en && wr_addr == SEL_ADDR)  sel_serial_q <= wr_data[0];
    end

    dma_int_src u_src (
        .sel_serial (sel_serial_q),
        .timer_drq  (timer_drq),
        .serial_drq (serial_drq),
        .int_drq    (int_drq)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        dma_chan_ctl #(
            .CNT_W  (CNT_W),
            .DATA_W (DATA_W)
        ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .ctl_we  (wr_en && (wr_addr == ADDR_W'(2 * g))),
            .cnt_we  (wr_en && (wr_addr == ADDR_W'(2 * g + 1))),
            .wr_data (wr_data),
            .ext_drq (ext_drq[g]),
            .int_drq (int_drq),
            .done_i  (xfer_done && busy[g]),
            .grant_i (grant[g]),
            .cand_o  (cand[g]),
            .busy_o  (busy[g]),
            .ctl_rd  (ctl_rd_a[g]),
            .cnt_rd  (cnt_rd_a[g])
        );
    end

    dma_req_arb #(.NUM_CH(NUM_CH)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .cand_i  (cand),
        .busy_i  (busy),
        .grant_o (grant)
    );

    always_comb begin
        xfer_req = grant;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_addr == ADDR_W'(2 * i))     rd_data = ctl_rd_a[i];
            if (rd_addr == ADDR_W'(2 * i + 1)) rd_data = DATA_W'(cnt_rd_a[i]);
        end
        if (rd_addr == SEL_ADDR) rd_data = DATA_W'(sel_serial_q);
    end

    // R8: select register follows its write
    p_sel_wr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (wr_addr == SEL_ADDR) |=> sel_serial_q == $past(wr_data[0]));

    // R11: outputs one-hot or idle
    p_req_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(xfer_req));
endmodule

// File: tb/dma_arm_ctrl_test.sv
module dma_arm_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [15:0] wr_data;
    logic [2:0]  rd_addr;
    logic [15:0] rd_data;
    logic [1:0]  ext_drq;
    logic        timer_drq, serial_drq, xfer_done;
    logic [1:0]  xfer_req;

    int n_chk = 0, n_fail = 0, cyc = 0;

    // reference model (from the requirements)
    int          m_st   [2];
    logic [1:0]  m_sync [2];
    logic        m_stop [2];
    logic        m_int  [2];
    logic [15:0] m_cnt  [2];
    logic        m_samp [2];
    logic        m_sel;

    always #2 clk = ~clk;

    dma_arm_ctrl uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ext_drq(ext_drq), .timer_drq(timer_drq), .serial_drq(serial_drq),
        .xfer_done(xfer_done), .xfer_req(xfer_req)
    );

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 60000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog R1 actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic m_drq(input int i);
        return m_int[i] ? (m_sel ? serial_drq : timer_drq) : ext_drq[i];
    endfunction

    function automatic logic [1:0] exp_req();
        logic [1:0] c;
        for (int i = 0; i < 2; i++)
            c[i] = (m_st[i] == 1) && ((m_sync[i] == 2'd0) ||
                   (m_sync[i] == 2'd1 && m_drq(i)) || (m_sync[i] == 2'd2 && m_samp[i]));
        if (m_st[0] == 2) return 2'b01;
        if (m_st[1] == 2) return 2'b10;
        if (c[0]) return 2'b01;
        if (c[1]) return 2'b10;
        return 2'b00;
    endfunction

    function automatic logic [15:0] exp_rd(input logic [2:0] a);
        if (a == 3'd4) return {15'd0, m_sel};
        for (int i = 0; i < 2; i++) begin
            if (a == 3'(2 * i))
                return {10'd0, m_int[i], m_stop[i], m_sync[i], 1'b0, m_st[i] != 0};
            if (a == 3'(2 * i + 1)) return m_cnt[i];
        end
        return 16'd0;
    endfunction

    task automatic model_next();
        logic [1:0] g;
        int         nst [2];
        logic       nsamp [2];
        g = exp_req();
        for (int i = 0; i < 2; i++) begin
            logic we_c, chg;
            we_c = wr_en && wr_addr == 3'(2 * i);
            chg  = we_c && wr_data[1];
            nsamp[i] = (m_st[i] == 1) ? m_drq(i) : 1'b0;
            nst[i] = m_st[i];
            case (m_st[i])
                0: if (chg && wr_data[0]) nst[i] = 1;
                1: if (chg && !wr_data[0]) nst[i] = 0; else if (g[i]) nst[i] = 2;
                default: if (chg && !wr_data[0]) nst[i] = 0;
                         else if (xfer_done) nst[i] = (m_cnt[i] == 16'd1 && m_stop[i]) ? 0 : 1;
            endcase
            if (wr_en && wr_addr == 3'(2 * i + 1)) m_cnt[i] = wr_data;
            else if (m_st[i] == 2 && xfer_done)   m_cnt[i] = m_cnt[i] - 16'd1;
            if (we_c) begin
                m_int[i]  = wr_data[5];
                m_stop[i] = wr_data[4];
                m_sync[i] = wr_data[5] ? 2'd1 : wr_data[3:2];
            end
        end
        for (int i = 0; i < 2; i++) begin
            m_st[i] = nst[i];
            m_samp[i] = nsamp[i];
        end
        if (wr_en && wr_addr == 3'd4) m_sel = wr_data[0];
    endtask

    // one cycle: inputs already driven after a falling edge
    task automatic tick_core(input string tag, input bit lr, input logic [1:0] lreq,
                             input bit lrd, input logic [15:0] lrdv);
        #1;
        chk(tag, xfer_req, exp_req());
        chk({tag, " R12 read"}, rd_data, exp_rd(rd_addr));
        if (lr)  chk({tag, " literal req"}, xfer_req, lreq);
        if (lrd) chk({tag, " literal read"}, rd_data, lrdv);
        model_next();
        @(negedge clk);
    endtask

    task automatic tick(input string tag);
        tick_core(tag, 0, 2'b00, 0, 16'd0);
    endtask

    task automatic tq(input string tag, input logic [1:0] r);
        tick_core(tag, 1, r, 0, 16'd0);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d, input string tag);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick(tag);
        wr_en = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h5eed_0019));
        rst_n = 1'b0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
        ext_drq = 0; timer_drq = 0; serial_drq = 0; xfer_done = 0;
        for (int i = 0; i < 2; i++) begin
            m_st[i] = 0; m_sync[i] = 0; m_stop[i] = 0; m_int[i] = 0;
            m_cnt[i] = 0; m_samp[i] = 0;
        end
        m_sel = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 5; a++) begin
            rd_addr = 3'(a);
            tick_core("R1 reset", 1, 2'b00, 1, 16'd0);
        end

        // R2 / R3: no change-enable, arm stays off, fields update
        ext_drq = 2'b11;
        wr(3'd0, 16'h0015, "R2 write");
        rd_addr = 3'd0;
        tick_core("R2 fields", 1, 2'b00, 1, 16'h0014);
        tq("R3 disarmed", 2'b00);

        // R12 / R5 / R9 / R10 source-paced, stop at zero
        wr(3'd1, 16'd3, "R9 load");
        wr(3'd0, 16'h0017, "R2 arm");
        tick_core("R12 arm readback", 1, 2'b01, 1, 16'h0015);
        ext_drq = 2'b00;
        tq("R11 hold", 2'b01);
        xfer_done = 1; tq("R9 done", 2'b01); xfer_done = 0;
        rd_addr = 3'd1;
        tick_core("R5 low", 1, 2'b00, 1, 16'd2);
        ext_drq = 2'b01;
        for (int k = 0; k < 2; k++) begin
            tq("R5 high", 2'b01);
            xfer_done = 1; tq("R9 done", 2'b01); xfer_done = 0;
        end
        rd_addr = 3'd0;
        tick_core("R10 stop", 1, 2'b00, 1, 16'h0014);
        rd_addr = 3'd1;
        tick_core("R10 count", 1, 2'b00, 1, 16'd0);
        ext_drq = 2'b00;

        // R4 / R10 free-running, no stop
        wr(3'd3, 16'd2, "R9 load");
        wr(3'd2, 16'h0003, "R4 arm");
        tq("R4 first", 2'b10);
        xfer_done = 1; tq("R4 done", 2'b10); xfer_done = 0;
        tq("R4 again", 2'b10);
        xfer_done = 1; tq("R4 done", 2'b10); xfer_done = 0;
        rd_addr = 3'd2;
        tick_core("R10 no-stop", 1, 2'b10, 1, 16'h0001);
        rd_addr = 3'd3;
        tick_core("R10 count zero", 1, 2'b10, 1, 16'd0);
        xfer_done = 1;
        wr(3'd2, 16'h0002, "R13 disarm with done");
        xfer_done = 0;
        rd_addr = 3'd2;
        tick_core("R13 off", 1, 2'b00, 1, 16'h0000);

        // R6 destination-paced
        ext_drq = 2'b01;
        wr(3'd1, 16'd10, "R9 load");
        wr(3'd0, 16'h000B, "R6 arm");
        tq("R6 sample lag", 2'b00);
        tq("R6 request", 2'b01);
        tq("R6 xfer", 2'b01);
        xfer_done = 1; tq("R6 done", 2'b01); xfer_done = 0;
        tq("R6 between", 2'b00);
        tq("R6 resume", 2'b01);
        xfer_done = 1; tq("R6 done", 2'b01); xfer_done = 0;
        wr(3'd0, 16'h0002, "R13 disarm");
        tq("R13 idle", 2'b00);

        // R7 reserved
        ext_drq = 2'b10;
        wr(3'd2, 16'h000F, "R7 arm");
        rd_addr = 3'd2;
        for (int k = 0; k < 3; k++) tick_core("R7 silent", 1, 2'b00, 1, 16'h000D);

        // R8 internal source, forced sync, module select
        ext_drq = 2'b00; serial_drq = 1;
        wr(3'd2, 16'h0023, "R8 write");
        tick_core("R8 forced", 1, 2'b00, 1, 16'h0025);
        timer_drq = 1;
        tq("R8 timer", 2'b10);
        xfer_done = 1; tq("R8 done", 2'b10); xfer_done = 0;
        timer_drq = 0;
        wr(3'd4, 16'h0001, "R8 select");
        tq("R8 serial", 2'b10);
        xfer_done = 1; tq("R8 done", 2'b10); xfer_done = 0;

        // R11 fixed priority
        serial_drq = 0;
        wr(3'd0, 16'h0007, "R11 arm ch0");
        ext_drq = 2'b01; serial_drq = 1;
        tq("R11 prio", 2'b01);
        ext_drq = 2'b00;
        tq("R11 block", 2'b01);
        xfer_done = 1; tq("R11 done", 2'b01); xfer_done = 0;
        tq("R11 next", 2'b10);

        // random phase
        for (int k = 0; k < 4000; k++) begin
            ext_drq    = 2'($urandom);
            timer_drq  = 1'($urandom);
            serial_drq = 1'($urandom);
            xfer_done  = ($urandom % 3) == 0;
            wr_en      = ($urandom % 8) == 0;
            wr_addr    = 3'($urandom % 5);
            wr_data    = wr_addr[0] ? 16'($urandom % 6) : 16'($urandom & 32'h3f);
            rd_addr    = 3'($urandom % 8);
            tick("R4 R5 R6 R7 R11 random");
        end
        wr_en = 0;

        summary();
        $finish;
    end
endmodule